// File: doc/BRIEF.md
# Serial Display Command/Data Transmitter

This block sends command and parameter bytes to a display panel over a serial link that has a chip select, a clock and one data line. A word arrives on a valid/ready stream. Each word carries a payload byte, a flag that marks it as data (1) or command (0), and a last marker. The block serialises the word MSB first on `dout`, using a clock `sck` that it derives from the system clock through a programmable half-period divider. `sck` idles low. `dout` changes while `sck` is low and is held while it is high, which is SPI mode 0.

Two wire modes are supported. In three-wire mode the command/data flag is sent in-band as a leading ninth bit. In four-wire mode the flag is driven on a separate `cd` pin for the whole word. Four-wire mode also has a wide transfer size. In that size each word is clocked as 16 bits: eight zero stuffing bits, then the payload byte. Chip select stays low over all words of a transaction, including stalls between words. It rises after the word marked last and then stays high for at least one full `sck` period. The mode, transfer size and divider are sampled when a transaction starts. Changes to them while the block is busy have no effect.

Top module: `dbi_serial_tx`

## Requirements
- R1: With `cfgMode` = 1 (three-wire), each word takes 9 rising `sck` edges. The first bit on `dout` is the data flag, followed by payload bits 7 down to 0. `cd` is held low in this mode.
- R2: With `cfgMode` = 2 (four-wire) and an 8-bit size, each word takes 8 rising `sck` edges, payload bit 7 first. `cd` equals the word's data flag.
- R3: `cd` stays constant over every rising `sck` edge of a word. It changes only when a new word is accepted.
- R4: With `cfgXferSize` = 16 in four-wire mode, each word takes 16 rising edges: eight zero bits, then payload bit 7 down to bit 0. With `cfgMode` = 1 the value 16 is ignored and each word stays at 9 bits.
- R5: `cfgMode` value 1 selects three-wire mode and any other value selects four-wire mode. `cfgXferSize` equal to 16 selects the wide size and any other value selects 8 bits. The flag value 1 marks data and 0 marks a command.
- R6: `csN` falls before the first rising edge of a transaction and stays low across back-to-back and stalled words. It rises only after all bits of the word accepted with `inLast` = 1, never inside a word.
- R7: After `csN` rises it stays high for at least 2*(`cfgDiv`+1) system clock cycles before it falls again. During that interval `inReady` is low.
- R8: While `csN` is high, `sck` is low. Each `sck` half period lasts `cfgDiv`+1 system clock cycles, so rising edges inside a word are 2*(`cfgDiv`+1) cycles apart. `dout` does not change while `sck` is high.
- R9: `busy` equals the inverse of `csN`. It rises only in the cycle after a word is accepted.
- R10: Changes to `cfgMode`, `cfgXferSize` and `cfgDiv` while `busy` is high do not alter the word length, the bit content or the `sck` timing of the transaction in progress.
- R11: After reset `csN` = 1, `sck` = 0, `busy` = 0 and `inReady` = 1. `inReady` is high only while `sck` is low, and only when the block is idle or between words of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Wire mode: 1 three-wire, otherwise four-wire |
| cfgXferSize | input | 5 | Transfer size: 16 wide, otherwise 8 |
| cfgDiv | input | DIV_W | `sck` half period minus one, in clk cycles |
| inValid | input | 1 | Word valid |
| inReady | output | 1 | Word accepted when high with inValid |
| inData | input | WORD_W | Payload byte |
| inIsData | input | 1 | 1 = data, 0 = command |
| inLast | input | 1 | Word ends the transaction |
| sck | output | 1 | Serial clock, idles low |
| dout | output | 1 | Serial data |
| csN | output | 1 | Chip select, active low |
| cd | output | 1 | Command/data level in four-wire mode |
| busy | output | 1 | High while csN is low |

## Verification
Two functions can land in the same cycle and must be checked together.

The first pair is the release of chip select after a last word and the offer of the first word of the next transaction. The bench raises `inValid` again as soon as the previous call returns, so the new word waits through the guard interval. The bench then checks that `csN` stayed high for the full guard time and that no bit was lost or split across the boundary.

The second pair is a configuration change and a transaction in flight. The bench scrambles the mode, size and divider one cycle after the first accepted word. It then compares every received word's length, content, `cd` level and `sck` spacing with values computed from the configuration that was present at the start of the transaction.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;
  localparam logic [1:0] MODE_THREE_WIRE = 2'd1;
  localparam logic [1:0] MODE_FOUR_WIRE  = 2'd2;
  localparam logic [4:0] XFER_WIDE       = 5'd16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_GUARD
  } txState_t;

  // strobes and word format from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic threeWire;
    logic wide;
  } dpStrobe_t;
endpackage

// File: rtl/dbi_tx_ctrl.sv
module dbi_tx_ctrl
  import dbi_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [4:0]       cfgXferSize,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             sck,
  output logic             csN,
  output logic             busy,
  output dpStrobe_t        strobe
);
  localparam int SHIFT_W = 2 * WORD_W;
  localparam int CNT_W   = $clog2(SHIFT_W + 1);
  localparam logic [CNT_W-1:0] LAST_THREE  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(SHIFT_W - 1);

  txState_t         state;
  logic [DIV_W-1:0] divCnt, divQ;
  logic [CNT_W-1:0] bitCnt, bitLoad;
  logic             threeQ, wideQ, lastQ, sckQ, csNQ, guardHalf;
  logic             tick, accept, threeSel, wideSel;

  always_comb begin
    inReady  = (state == ST_IDLE) || (state == ST_WAIT);
    accept   = inValid && inReady;
    tick     = (divCnt == divQ);
    threeSel = (state == ST_IDLE) ? (cfgMode == MODE_THREE_WIRE) : threeQ;
    wideSel  = (state == ST_IDLE) ? ((cfgMode != MODE_THREE_WIRE) && (cfgXferSize == XFER_WIDE))
                                  : wideQ;
    bitLoad  = threeSel ? LAST_THREE : (wideSel ? LAST_WIDE : LAST_NARROW);
    strobe.load      = accept;
    strobe.shift     = (state == ST_HIGH) && tick && (bitCnt != '0);
    strobe.threeWire = threeSel;
    strobe.wide      = wideSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      divQ      <= '0;
      bitCnt    <= '0;
      threeQ    <= 1'b0;
      wideQ     <= 1'b0;
      lastQ     <= 1'b0;
      sckQ      <= 1'b0;
      csNQ      <= 1'b1;
      guardHalf <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_WAIT: begin
          if (accept) begin
            if (state == ST_IDLE) begin
              divQ   <= cfgDiv;
              threeQ <= threeSel;
              wideQ  <= wideSel;
            end
            bitCnt <= bitLoad;
            lastQ  <= inLast;
            divCnt <= '0;
            csNQ   <= 1'b0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            divCnt <= '0;
            sckQ   <= 1'b1;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            divCnt <= '0;
            sckQ   <= 1'b0;
            if (bitCnt != '0) begin
              bitCnt <= bitCnt - 1'b1;
              state  <= ST_LOW;
            end else if (lastQ) begin
              csNQ      <= 1'b1;
              guardHalf <= 1'b0;
              state     <= ST_GUARD;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (tick) begin
            divCnt    <= '0;
            guardHalf <= 1'b1;
            if (guardHalf) state <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck  = sckQ;
  assign csN  = csNQ;
  assign busy = !csNQ;
endmodule

// File: rtl/dbi_tx_datapath.sv
module dbi_tx_datapath
  import dbi_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic              inIsData,
  output logic              dout,
  output logic              cd
);
  localparam int SHIFT_W = 2 * WORD_W;

  logic [SHIFT_W-1:0] shiftQ, loadVal;
  logic               cdQ;

  always_comb begin
    if (strobe.threeWire)
      loadVal = {inIsData, inData, {(SHIFT_W-WORD_W-1){1'b0}}};
    else if (strobe.wide)
      loadVal = {{WORD_W{1'b0}}, inData};
    else
      loadVal = {inData, {WORD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      cdQ    <= 1'b0;
    end else if (strobe.load) begin
      shiftQ <= loadVal;
      cdQ    <= strobe.threeWire ? 1'b0 : inIsData;
    end else if (strobe.shift) begin
      shiftQ <= {shiftQ[SHIFT_W-2:0], 1'b0};
    end
  end

  assign dout = shiftQ[SHIFT_W-1];
  assign cd   = cdQ;
endmodule

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx
  import dbi_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic [4:0]        cfgXferSize,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inIsData,
  input  logic              inLast,
  output logic              sck,
  output logic              dout,
  output logic              csN,
  output logic              cd,
  output logic              busy
);
  dpStrobe_t strobe;

  dbi_tx_ctrl #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgXferSize(cfgXferSize),
    .cfgDiv(cfgDiv), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .sck(sck), .csN(csN), .busy(busy), .strobe(strobe)
  );

  dbi_tx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .inIsData(inIsData), .dout(dout), .cd(cd)
  );
endmodule

// File: rtl/dbi_serial_tx_checker.sv
module dbi_serial_tx_checker (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic dout,
  input logic csN,
  input logic cd,
  input logic busy,
  input logic inValid,
  input logic inReady
);
  assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(dout));

  assert_cd_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cd) |-> $past(inValid && inReady));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inValid && inReady));

  assert_guard_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !inReady);

  assert_ready_low_sck_R11: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !sck);
endmodule

bind dbi_serial_tx dbi_serial_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .dout(dout), .csN(csN), .cd(cd),
  .busy(busy), .inValid(inValid), .inReady(inReady)
);

// File: tb/dbi_serial_tx_test.sv
module dbi_serial_tx_test;
  localparam int MAXW = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgMode = 2'd2;
  logic [4:0] cfgXferSize = 5'd8;
  logic [7:0] cfgDiv = 8'd0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'd0;
  logic       inIsData = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, sck, dout, csN, cd, busy;

  dbi_serial_tx uut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgXferSize(cfgXferSize),
    .cfgDiv(cfgDiv), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inIsData(inIsData), .inLast(inLast), .sck(sck), .dout(dout), .csN(csN),
    .cd(cd), .busy(busy)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // expected words
  int          expBits [MAXW];
  logic [15:0] expVal  [MAXW];
  logic        expCd   [MAXW];
  int          expDiv  [MAXW];
  logic        expLast [MAXW];
  int wrIdx = 0;
  int rdIdx = 0;

  // configuration of the transaction being queued
  bit txThree, txWide;
  int txDiv;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wordBits(input bit three, input bit wide);
    return three ? 9 : (wide ? 16 : 8);
  endfunction

  function automatic logic [15:0] wordVal(input bit three, input logic [7:0] d, input logic f);
    return three ? {7'd0, f, d} : {8'd0, d};
  endfunction

  // ---------------- monitor ----------------
  logic        prevSck = 1'b0, prevCs = 1'b1, prevDout = 1'b0, cd0 = 1'b0;
  int          rxCnt = 0, cyc = 0, lastRise = 0, highCnt = 0;
  logic [15:0] rxWord = '0;
  bit          seenTxn = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN && !done) begin
      check(busy === !csN, "R9 busy vs csN", busy, !csN);
      if (csN && sck) check(1'b0, "R8 sck idle low", sck, 0);
      if (sck && prevSck && dout !== prevDout) check(1'b0, "R8 dout held while sck high", dout, prevDout);
      if (sck && !prevSck) begin
        if (csN) check(1'b0, "R6 rising edge with csN high", csN, 0);
        if (rxCnt == 0) begin
          cd0 = cd;
          rxWord = '0;
        end else begin
          check(cd === cd0, "R3 cd stable in word", cd, cd0);
          check(cyc - lastRise == 2 * (expDiv[rdIdx] + 1), "R8 sck period",
                cyc - lastRise, 2 * (expDiv[rdIdx] + 1));
        end
        lastRise = cyc;
        rxWord = {rxWord[14:0], dout};
        rxCnt++;
        if (rdIdx < wrIdx && rxCnt == expBits[rdIdx]) begin
          if (expBits[rdIdx] == 9)       check(rxWord === expVal[rdIdx], "R1 three-wire word", rxWord, expVal[rdIdx]);
          else if (expBits[rdIdx] == 16) check(rxWord === expVal[rdIdx], "R4 wide word", rxWord, expVal[rdIdx]);
          else                           check(rxWord === expVal[rdIdx], "R2 four-wire word", rxWord, expVal[rdIdx]);
          check(cd0 === expCd[rdIdx], "R5 cd level", cd0, expCd[rdIdx]);
          rdIdx++;
          rxCnt = 0;
        end else if (rdIdx >= wrIdx) begin
          check(1'b0, "R6 unexpected bit", rxCnt, 0);
        end
      end
      if (csN && !prevCs) begin
        check(rxCnt == 0 && rdIdx > 0 && expLast[rdIdx-1], "R6 csN release at last word end", rxCnt, 0);
        highCnt = 0;
      end
      if (!csN && prevCs) begin
        if (seenTxn)
          check(highCnt >= 2 * (expDiv[rdIdx-1] + 1), "R7 guard length", highCnt, 2 * (expDiv[rdIdx-1] + 1));
        seenTxn = 1'b1;
      end
      if (csN) highCnt++;
      prevSck  = sck;
      prevCs   = csN;
      prevDout = dout;
    end
  end

  // ---------------- driver ----------------
  task automatic sendWord(input logic [7:0] d, input logic f, input logic last, input bit scramble);
    expBits[wrIdx] = wordBits(txThree, txWide);
    expVal[wrIdx]  = wordVal(txThree, d, f);
    expCd[wrIdx]   = txThree ? 1'b0 : f;
    expDiv[wrIdx]  = txDiv;
    expLast[wrIdx] = last;
    wrIdx++;
    inData = d; inIsData = f; inLast = last; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    if (scramble) begin // R10: change config while busy
      check(busy === 1'b1, "R10 busy during scramble", busy, 1);
      cfgMode = txThree ? 2'd2 : 2'd1;
      cfgXferSize = txWide ? 5'd8 : 5'd16;
      cfgDiv = 8'(txDiv + 2);
    end
  endtask

  task automatic startTxn(input logic [1:0] m, input logic [4:0] sz, input int dv);
    while (busy) @(negedge clk);
    cfgMode = m; cfgXferSize = sz; cfgDiv = 8'(dv);
    txThree = (m == 2'd1);
    txWide  = !txThree && (sz == 5'd16);
    txDiv   = dv;
  endtask

  task automatic randTxn;
    int n;
    logic [1:0] m;
    m = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
    startTxn(m, ($urandom % 2 == 0) ? 5'd16 : 5'd8, int'($urandom % 4));
    n = 1 + int'($urandom % 5);
    for (int i = 0; i < n; i++) begin
      sendWord(8'($urandom), 1'($urandom), i == n - 1, i == 0);
      if ($urandom % 3 == 0) repeat (1 + $urandom % 20) @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R11 reset state
    check(csN === 1'b1, "R11 reset csN", csN, 1);
    check(sck === 1'b0, "R11 reset sck", sck, 0);
    check(busy === 1'b0, "R11 reset busy", busy, 0);
    check(inReady === 1'b1, "R11 reset inReady", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R1 directed: three-wire command byte
    startTxn(2'd1, 5'd8, 1);
    sendWord(8'hA5, 1'b0, 1'b1, 1'b0);
    // R2 directed: four-wire back to back, fastest divider
    startTxn(2'd2, 5'd8, 0);
    sendWord(8'h3C, 1'b0, 1'b0, 1'b0);
    sendWord(8'hC3, 1'b1, 1'b0, 1'b0);
    sendWord(8'h81, 1'b1, 1'b1, 1'b0);
    // R4 directed: wide size, all-ones payload
    startTxn(2'd2, 5'd16, 2);
    sendWord(8'hFF, 1'b1, 1'b0, 1'b0);
    sendWord(8'h01, 1'b0, 1'b1, 1'b0);
    // R4 directed: size 16 ignored in three-wire mode
    startTxn(2'd1, 5'd16, 0);
    sendWord(8'hFF, 1'b1, 1'b1, 1'b0);
    // R6 stalled words keep csN low
    startTxn(2'd2, 5'd8, 1);
    sendWord(8'h5A, 1'b0, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    check(csN === 1'b0, "R6 csN low during stall", csN, 0);
    sendWord(8'hA5, 1'b1, 1'b1, 1'b0);
    // R10 directed scramble then random mix
    startTxn(2'd1, 5'd8, 3);
    sendWord(8'h96, 1'b1, 1'b0, 1'b1);
    sendWord(8'h69, 1'b0, 1'b1, 1'b0);
    for (int t = 0; t < 40; t++) randTxn();

    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(rdIdx == wrIdx, "R6 all words delivered", rdIdx, wrIdx);
    check(csN === 1'b1 && sck === 1'b0, "R8 idle after traffic", {csN, sck}, 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog expired rdIdx=%0d wrIdx=%0d", rdIdx, wrIdx);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule